// File: doc/BRIEF.md
# Per-Channel Test Pattern Datapath

This block produces a test bit stream for a row of modulator-driver lanes. A single source drives the whole row. That source is either a built-in pseudo-random generator with a period of 2^15-1 bits or a serial input brought in from outside. The stream travels at half rate as two single-data-rate lanes. Each clock carries one even bit and the odd bit that follows it.

Each channel takes the shared stream and delays it by 0 to 15 full-rate bit times. It can then invert the stream. Adjacent drivers can therefore be given streams that are shifted or complemented relative to one another, which makes neighbouring drivers carry uncorrelated patterns. At the channel end the two lanes become one double-rate bit. That bit shows the even lane while the clock is high and the odd lane while the clock is low.

Top module: `ptp_datapath`

## Requirements
- R1: A synchronous reset clears the source register, the shared bit history and every channel output pair to zero. The first pair after reset is released is all zero.
- R2: With the internal source selected, the captured stream s follows s[n] = s[n-14] XOR s[n-15]. At reset the history s[-15..-1] is all ones. Each clock supplies s[2k] on the even lane (pair bit 0) and s[2k+1] on the odd lane (pair bit 1).
- R3: The generator state is never all zero, so the internal sequence repeats every 32767 bits.
- R4: With `src_ext_i` at 1, the even and odd lanes of capture k take `ext_even_i` and `ext_odd_i` as sampled at clock edge k. With `src_ext_i` at 0, the generator supplies them.
- R5: When a channel's invert bit is 1, both bits of its pair are complemented. The delay alignment is not changed by this.
- R6: Take a channel whose delay field (DLY_W bits at offset c*DLY_W) holds D. Its even bit is s[2k-D] and its odd bit is s[2k+1-D]. An odd D therefore moves bits across lanes. Bits before reset count as zero.
- R7: A pair captured at clock edge k appears on `pair_o` after edge k+1. The delay and invert values used are the ones sampled at edge k+1.
- R8: `ddr_o[c]` equals the even bit of channel c while the clock is high and the odd bit while the clock is low.
- R9: A channel's invert and delay settings affect only that channel's outputs.
- R10: The generator advances on every clock out of reset, whatever source is selected. Returning to the internal source resumes the sequence at the point it has reached by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate clock; its level also selects the double-rate phase |
| rst_i | input | 1 | Synchronous reset, active high |
| src_ext_i | input | 1 | 1 selects the external bits, 0 the internal generator |
| ext_even_i | input | 1 | External even-lane bit |
| ext_odd_i | input | 1 | External odd-lane bit |
| inv_i | input | NUM_CH | Per-channel complement enable |
| dly_i | input | NUM_CH*DLY_W | Per-channel delay in full-rate bits, channel c at bits c*DLY_W upward |
| pair_o | output | 2*NUM_CH | Per-channel pair, bit 2c even, bit 2c+1 odd |
| ddr_o | output | NUM_CH | Per-channel double-rate bit |

## Verification
The hardest situation to reach from the ports is a delay larger than the generator taps combined with odd lane swapping. On top of that, the source changes while older bits are still in the shared history. The stimulus gives each channel a different delay at the same moment (0, 1, 7 and 15, then 2, 3, 14 and 0) and sets inversion differently per channel. It switches to external random bits and back while those windows span the switch. A run of over 16,000 clocks covers a full generator period. Every pair and both double-rate phases are compared against a bit-level model of the stream.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

    localparam int PRBS_LEN = 15;
    localparam int PRBS_TAP = 14;
    localparam logic [PRBS_LEN-1:0] PRBS_SEED = '1;

    typedef enum logic {
        SRC_PRBS = 1'b0,
        SRC_EXT  = 1'b1
    } src_sel_e;

    // bit 0 carries the earlier (even) full-rate bit
    typedef struct packed {
        logic odd;
        logic even;
    } lane_pair_t;

endpackage

// File: rtl/ptp_prbs2.sv
// Two-bit-per-clock Fibonacci generator, s[n] = s[n-TAP] ^ s[n-LEN].
// state_q[i] holds s[n-1-i], so state_q[0] is the newest bit.
module ptp_prbs2
    import ptp_pkg::*;
#(
    parameter int LEN = PRBS_LEN,
    parameter int TAP = PRBS_TAP,
    parameter logic [LEN-1:0] SEED = PRBS_SEED
) (
    input  logic       clk_i,
    input  logic       rst_i,
    output lane_pair_t bits_o
);

    typedef struct packed {
        logic [LEN-1:0] state;
    } prbs_regs_t;

    prbs_regs_t r_q, r_d;
    logic       nxt_even, nxt_odd;

    always_comb begin
        nxt_even = r_q.state[TAP-1] ^ r_q.state[LEN-1];
        nxt_odd  = r_q.state[TAP-2] ^ r_q.state[LEN-2];
        r_d       = r_q;
        r_d.state = {r_q.state[LEN-3:0], nxt_even, nxt_odd};
        bits_o.even = nxt_even;
        bits_o.odd  = nxt_odd;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '{state: SEED};
        else       r_q <= r_d;
    end

    logic [3:0] age_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)              age_q <= '0;
        else if (age_q != 4'hF) age_q <= age_q + 4'd1;
    end

    assert_state_nonzero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        r_q.state != '0);

    generate
        if (LEN == 15 && TAP == 14) begin : g_rec_chk
            // even(t) = s[2t] = s[2t-14] ^ s[2t-15] = even(t-7) ^ odd(t-8)
            assert_recurrence_R2: assert property (@(posedge clk_i) disable iff (rst_i)
                (age_q >= 4'd8) |-> (bits_o.even == ($past(bits_o.even, 7) ^ $past(bits_o.odd, 8))));
        end
    endgenerate

endmodule

// File: rtl/ptp_ddr_merge.sv
// Clock-level mux: even lane in the high phase, odd lane in the low phase.
module ptp_ddr_merge
    import ptp_pkg::*;
(
    input  logic       clk_i,
    input  lane_pair_t pair_i,
    output logic       ddr_o
);

    always_comb begin
        ddr_o = clk_i ? pair_i.even : pair_i.odd;
    end

endmodule

// File: rtl/ptp_tap.sv
// Per-channel delay tap on the shared window, then complement, then register.
// win_i[0] is the newest (odd) bit; win_i[j] is j full-rate bits older.
module ptp_tap
    import ptp_pkg::*;
#(
    parameter int DLY_W = 4,
    parameter int WIN_W = (1 << DLY_W) + 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             inv_i,
    output lane_pair_t       pair_o,
    output logic             ddr_o
);

    typedef struct packed {
        lane_pair_t pair;
    } tap_regs_t;

    tap_regs_t r_q, r_d;
    int unsigned sel_odd, sel_even;

    always_comb begin
        sel_odd  = int'(dly_i);
        sel_even = int'(dly_i) + 1;
        r_d = r_q;
        // inversion is applied after selection, so alignment never shifts
        r_d.pair.odd  = win_i[sel_odd]  ^ inv_i;
        r_d.pair.even = win_i[sel_even] ^ inv_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign pair_o = r_q.pair;

    ptp_ddr_merge u_merge (
        .clk_i  (clk_i),
        .pair_i (r_q.pair),
        .ddr_o  (ddr_o)
    );

endmodule

// File: rtl/ptp_datapath.sv
module ptp_datapath
    import ptp_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DLY_W  = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    src_ext_i,
    input  logic                    ext_even_i,
    input  logic                    ext_odd_i,
    input  logic [NUM_CH-1:0]       inv_i,
    input  logic [NUM_CH*DLY_W-1:0] dly_i,
    output logic [2*NUM_CH-1:0]     pair_o,
    output logic [NUM_CH-1:0]       ddr_o
);

    localparam int MAX_DLY = (1 << DLY_W) - 1;
    localparam int HIST_W  = MAX_DLY;
    localparam int WIN_W   = HIST_W + 2;

    typedef struct packed {
        lane_pair_t        src;
        logic [HIST_W-1:0] hist;   // hist[0] newest
    } dp_regs_t;

    dp_regs_t         r_q, r_d;
    lane_pair_t       gen_bits;
    lane_pair_t       sel_bits;
    logic [WIN_W-1:0] win;
    src_sel_e         src_sel;

    ptp_prbs2 u_prbs (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .bits_o (gen_bits)
    );

    always_comb begin
        src_sel = src_sel_e'(src_ext_i);
        case (src_sel)
            SRC_EXT: begin
                sel_bits.even = ext_even_i;
                sel_bits.odd  = ext_odd_i;
            end
            default: sel_bits = gen_bits;
        endcase
        win    = {r_q.hist, r_q.src.even, r_q.src.odd};
        r_d      = r_q;
        r_d.src  = sel_bits;
        r_d.hist = {r_q.hist[HIST_W-3:0], r_q.src.even, r_q.src.odd};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    lane_pair_t ch_pair [NUM_CH];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            ptp_tap #(
                .DLY_W (DLY_W),
                .WIN_W (WIN_W)
            ) u_tap (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .win_i  (win),
                .dly_i  (dly_i[c*DLY_W +: DLY_W]),
                .inv_i  (inv_i[c]),
                .pair_o (ch_pair[c]),
                .ddr_o  (ddr_o[c])
            );
            assign pair_o[2*c]   = ch_pair[c].even;
            assign pair_o[2*c+1] = ch_pair[c].odd;
        end
    endgenerate

    // ---------------- assertions ----------------
    logic [1:0] age_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)              age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            assert_ext_latency_R7: assert property (@(posedge clk_i) disable iff (rst_i)
                ((age_q >= 2'd2) && $past(src_ext_i, 2) &&
                 ($past(dly_i[c*DLY_W +: DLY_W]) == '0) && !$past(inv_i[c]))
                |-> (pair_o[2*c] == $past(ext_even_i, 2) && pair_o[2*c+1] == $past(ext_odd_i, 2)));
        end
        for (genvar c = 0; c + 1 < NUM_CH; c++) begin : g_inv_chk
            assert_inv_complement_R5: assert property (@(posedge clk_i) disable iff (rst_i)
                ((age_q >= 2'd1) &&
                 ($past(dly_i[c*DLY_W +: DLY_W]) == $past(dly_i[(c+1)*DLY_W +: DLY_W])) &&
                 ($past(inv_i[c]) != $past(inv_i[c+1])))
                |-> (pair_o[2*c +: 2] == ~pair_o[2*(c+1) +: 2]));
        end
        if (NUM_CH >= 2) begin : g_swap_chk
            assert_odd_delay_swap_R6: assert property (@(posedge clk_i) disable iff (rst_i)
                ((age_q >= 2'd2) &&
                 ($past(dly_i[0 +: DLY_W]) == 1) && ($past(dly_i[DLY_W +: DLY_W]) == 0) &&
                 ($past(inv_i[0]) == $past(inv_i[1])) &&
                 ($past(dly_i[0 +: DLY_W], 2) == 1) && ($past(dly_i[DLY_W +: DLY_W], 2) == 0) &&
                 ($past(inv_i[0], 2) == $past(inv_i[1], 2)))
                |-> (pair_o[1] == pair_o[2] && pair_o[0] == $past(pair_o[3])));
        end
    endgenerate

endmodule

// File: tb/tb_ptp_datapath.sv
module tb_ptp_datapath;

    localparam int CLK_NS = 10;
    localparam int NCH    = 4;
    localparam int DW     = 4;
    localparam int WIN    = (1 << DW) + 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sel = 1'b0;
    logic            ext_e = 1'b0, ext_o = 1'b0;
    logic [NCH-1:0]  inv = '0;
    logic [NCH*DW-1:0] dly = '0;
    logic [2*NCH-1:0] pair;
    logic [NCH-1:0]  ddr;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    always #(CLK_NS/2) clk = ~clk;

    ptp_datapath #(.NUM_CH(NCH), .DLY_W(DW)) dut (
        .clk_i(clk), .rst_i(rst), .src_ext_i(sel),
        .ext_even_i(ext_e), .ext_odd_i(ext_o),
        .inv_i(inv), .dly_i(dly), .pair_o(pair), .ddr_o(ddr)
    );

    // ---------- driver: computes the captured stream and queues it ----------
    logic [14:0] mstate = '1;
    logic [31:0] lcg = 32'h1234_5678;
    logic        sq[$];

    task automatic push_pair();
        logic pe, po, ge, go;
        ge = mstate[13] ^ mstate[14];
        go = mstate[12] ^ mstate[13];
        mstate = {mstate[12:0], ge, go};   // R10: model advances every cycle
        lcg = lcg * 32'd1103515245 + 32'd12345;
        ext_e = lcg[16];
        ext_o = lcg[19];
        pe = sel ? ext_e : ge;
        po = sel ? ext_o : go;
        sq.push_back(pe);
        sq.push_back(po);
    endtask

    always @(negedge clk) begin
        if (rst) mstate = '1;
        else     push_pair();
    end

    task automatic check(input string t, input int ch, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ch%0d %s actual %0b expected %0b", t, ch, what, act, exp);
        end
    endtask

    // ---------- monitor: pops stream bits and compares every channel ----------
    logic sw [WIN];
    logic first = 1'b1;
    logic exp_odd [NCH];

    always @(posedge clk) begin
        #(CLK_NS/4);
        if (rst) begin
            first = 1'b1;
            for (int j = 0; j < WIN; j++) sw[j] = 1'b0;
            sq.delete();
            for (int c = 0; c < NCH; c++) begin
                check("R1", c, "pair in reset", pair[2*c+1 -: 2] != 2'b00, 1'b0);
                exp_odd[c] = 1'b0;
            end
        end else begin
            if (!first) begin
                for (int j = WIN-1; j >= 2; j--) sw[j] = sw[j-2];
                sw[1] = sq.pop_front();
                sw[0] = sq.pop_front();
            end
            for (int c = 0; c < NCH; c++) begin
                int d;
                logic ee, eo;
                string t;
                d  = int'(dly[c*DW +: DW]);
                ee = sw[d+1] ^ inv[c];
                eo = sw[d] ^ inv[c];
                t  = first ? "R1" : tag;
                check(t, c, "even (R6 R7)", pair[2*c], ee);
                check(t, c, "odd (R6 R7)", pair[2*c+1], eo);
                check({t, " R8"}, c, "ddr high phase", ddr[c], ee);
                exp_odd[c] = eo;
            end
            first = 1'b0;
        end
        #(CLK_NS/2);
        for (int c = 0; c < NCH; c++)
            check("R8", c, "ddr low phase", ddr[c], exp_odd[c]);
    end

    // ---------- control: changes land between the monitor and the driver ----------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #(CLK_NS*3/8);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        tag = "R2";                       // internal source, no delay, no invert
        step(40);
        tag = "R5 R6 R9";                 // distinct delays and inversions
        dly = {4'd15, 4'd7, 4'd1, 4'd0};
        inv = 4'b1010;
        step(40);
        tag = "R4 R6 R9";                 // external source, delays straddle the switch
        sel = 1'b1;
        dly = {4'd0, 4'd14, 4'd3, 4'd2};
        inv = 4'b0110;
        step(60);
        tag = "R10 R2";                   // return to the generator mid-sequence
        sel = 1'b0;
        dly = {4'd1, 4'd0, 4'd1, 4'd0};
        inv = 4'b0000;
        step(30);
        tag = "R3 R2";                    // beyond one full generator period
        dly = {4'd9, 4'd4, 4'd0, 4'd15};
        inv = 4'b1001;
        step(16500);
        tag = "R1";                       // mid-run reset
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        dly = '0;
        inv = '0;
        tag = "R1 R2";
        step(30);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS*200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule